// File: doc/BRIEF.md
# Flash Controller Interrupt Unit

This block gathers the eight event sources of a serial flash controller into one level-sensitive interrupt line. Each source arrives as a single-cycle pulse. The pulse is latched into a raw status bit, and the bit stays set until software writes a one to the matching position of a clear register. A per-source mask decides which latched events may reach the interrupt line. A masked status view shows which enabled sources are pending.

Software sees four word registers on a simple register bus. The bus has an address, write data with a write strobe, and a read strobe; read data is returned from a register. Raw status keeps recording events while they are masked. A handler can therefore poll sources it has disabled, and it must clear them explicitly, for example after a recovery of the controller's state machines. The system reset leaves every source disabled.

Top module: `flash_irq_unit`

## Requirements
- R1: After the synchronous active-high reset, raw status is 0, the mask register holds all ones (every source disabled), masked status is 0 and `irq_o` is low.
- R2: Source bit positions are the same in `evt_pulse` and in all four registers: bit 0 receive FIFO full, 1 receive underflow, 2 transmit overflow, 3 transmit FIFO empty, 4 transfer finished, 5 bus error, 6 protocol error, 7 DMA done.
- R3: A one on `evt_pulse[i]` sampled at a clock edge sets raw bit i at that edge, whatever the value of mask bit i.
- R4: A write to the clear register clears every raw bit whose data bit is 1. Raw bits whose data bit is 0 keep their value, and writing all ones clears every source.
- R5: When an event and a clear for the same bit fall in the same cycle, the event wins and the raw bit remains 1.
- R6: The masked status register reads as raw status AND NOT mask.
- R7: `irq_o` is a register holding the OR of the masked status bits. It rises on the second clock edge after the event is sampled, and a source whose mask bit is 1 never drives it.
- R8: A write to the mask register stores the low 8 data bits, and a read of it returns them.
- R9: Bits 31:8 of every register read as zero and ignore written data. Writes to the raw and masked status addresses have no effect, and the clear register reads as zero.
- R10: Word addresses are 0 raw status, 1 mask, 2 masked status, 3 clear. A read strobe sampled at an edge returns the addressed register's pre-edge value on `bus_rdata` after that edge, and other addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| evt_pulse | input | 8 | Single-cycle event pulses, one per source |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The two functions that can meet in one cycle are the arrival of an event pulse and a software write to the clear register for the same bit. The bench drives both in the same cycle, with other bits of the same clear word aimed at idle sources. It then reads raw status and expects the colliding bit still set while the bits with no event are cleared. A second collision, a mask write while an enabled source is pending, is judged through `irq_o` and masked status.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;

  // Register word offsets
  localparam int unsigned OFS_RAW   = 0;
  localparam int unsigned OFS_MASK  = 1;
  localparam int unsigned OFS_MSTAT = 2;
  localparam int unsigned OFS_CLR   = 3;

  // Source bit positions
  localparam int unsigned SRC_RX_FULL   = 0;
  localparam int unsigned SRC_RX_UNDER  = 1;
  localparam int unsigned SRC_TX_OVER   = 2;
  localparam int unsigned SRC_TX_EMPTY  = 3;
  localparam int unsigned SRC_XFER_DONE = 4;
  localparam int unsigned SRC_BUS_ERR   = 5;
  localparam int unsigned SRC_PROTO_ERR = 6;
  localparam int unsigned SRC_DMA_DONE  = 7;

  // One-hot register select
  typedef struct packed {
    logic raw;
    logic mask;
    logic mstat;
    logic clr;
  } reg_hit_t;

endpackage

// File: rtl/flash_irq_status_bank.sv
module flash_irq_status_bank #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] evt,
  input  logic             clr_we,
  input  logic [N_SRC-1:0] clr_bits,
  output logic [N_SRC-1:0] raw_q
);

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    // Event has priority over a clear in the same cycle
    always_ff @(posedge clk) begin
      if (rst)
        raw_q[i] <= 1'b0;
      else if (evt[i])
        raw_q[i] <= 1'b1;
      else if (clr_we && clr_bits[i])
        raw_q[i] <= 1'b0;
    end

    assert_event_sets_R3: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> raw_q[i]);

    assert_event_beats_clear_R5: assert property (@(posedge clk) disable iff (rst)
      (evt[i] && clr_we && clr_bits[i]) |=> raw_q[i]);

    assert_clear_works_R4: assert property (@(posedge clk) disable iff (rst)
      (!evt[i] && clr_we && clr_bits[i]) |=> !raw_q[i]);

    assert_idle_holds_R4: assert property (@(posedge clk) disable iff (rst)
      (!evt[i] && !(clr_we && clr_bits[i])) |=> $stable(raw_q[i]));
  end

endmodule

// File: rtl/flash_irq_mask_reg.sv
module flash_irq_mask_reg #(
  parameter int unsigned       N_SRC    = 8,
  parameter logic [N_SRC-1:0]  MASK_RST = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [N_SRC-1:0] wbits,
  output logic [N_SRC-1:0] mask_q
);

  always_ff @(posedge clk) begin
    if (rst)
      mask_q <= MASK_RST;
    else if (we)
      mask_q <= wbits;
  end

  assert_mask_init_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == MASK_RST));

  assert_mask_write_R8: assert property (@(posedge clk) disable iff (rst)
    we |=> (mask_q == $past(wbits)));

  assert_mask_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(mask_q));

endmodule

// File: rtl/flash_irq_read_port.sv
module flash_irq_read_port
  import flash_irq_pkg::*;
#(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              re,
  input  reg_hit_t          hit,
  input  logic [N_SRC-1:0]  raw,
  input  logic [N_SRC-1:0]  mask,
  output logic [N_SRC-1:0]  mstat,
  output logic [DATA_W-1:0] rdata_q
);

  logic [DATA_W-1:0] rd_next;

  assign mstat = raw & ~mask;

  always_comb begin
    rd_next = '0;
    if (hit.raw)
      rd_next[N_SRC-1:0] = raw;
    else if (hit.mask)
      rd_next[N_SRC-1:0] = mask;
    else if (hit.mstat)
      rd_next[N_SRC-1:0] = mstat;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (re)
      rdata_q <= rd_next;
  end

  assert_read_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata_q));

  assert_read_raw_R10: assert property (@(posedge clk) disable iff (rst)
    (re && hit.raw) |=> (rdata_q[N_SRC-1:0] == $past(raw)));

endmodule

// File: rtl/flash_irq_unit.sv
module flash_irq_unit
  import flash_irq_pkg::*;
#(
  parameter int unsigned      N_SRC    = 8,
  parameter int unsigned      DATA_W   = 32,
  parameter int unsigned      ADDR_W   = 4,
  parameter logic [N_SRC-1:0] MASK_RST = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_SRC-1:0]  evt_pulse,
  output logic              irq_o
);

  reg_hit_t         hit;
  logic [N_SRC-1:0] raw_q;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] mstat;
  logic             irq_q;

  always_comb begin
    hit.raw   = (bus_addr == ADDR_W'(OFS_RAW));
    hit.mask  = (bus_addr == ADDR_W'(OFS_MASK));
    hit.mstat = (bus_addr == ADDR_W'(OFS_MSTAT));
    hit.clr   = (bus_addr == ADDR_W'(OFS_CLR));
  end

  if (DATA_W > N_SRC) begin : g_hi_tie
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:N_SRC];
  end

  flash_irq_status_bank #(.N_SRC(N_SRC)) u_status (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt_pulse),
    .clr_we   (bus_we && hit.clr),
    .clr_bits (bus_wdata[N_SRC-1:0]),
    .raw_q    (raw_q)
  );

  flash_irq_mask_reg #(.N_SRC(N_SRC), .MASK_RST(MASK_RST)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .we     (bus_we && hit.mask),
    .wbits  (bus_wdata[N_SRC-1:0]),
    .mask_q (mask_q)
  );

  flash_irq_read_port #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .re      (bus_re),
    .hit     (hit),
    .raw     (raw_q),
    .mask    (mask_q),
    .mstat   (mstat),
    .rdata_q (bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst)
      irq_q <= 1'b0;
    else
      irq_q <= |mstat;
  end

  assign irq_o = irq_q;

  assert_irq_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    ((raw_q & ~mask_q) == '0) |=> !irq_o);

  assert_irq_raised_R7: assert property (@(posedge clk) disable iff (rst)
    ((raw_q & ~mask_q) != '0) |=> irq_o);

  assert_rdata_hi_R9: assert property (@(posedge clk) disable iff (rst)
    bus_re |=> (bus_rdata[DATA_W-1:N_SRC] == '0));

endmodule

// File: tb/flash_irq_unit_test.sv
module flash_irq_unit_test;
  import flash_irq_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  evt_pulse = '0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_raw = 8'h00;
  logic [7:0] m_mask = 8'hFF;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_pending = 1'b0;

  always #2 clk = ~clk;

  flash_irq_unit uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .evt_pulse(evt_pulse), .irq_o(irq_o)
  );

  // Monitor: pop expected read data one edge after a read strobe
  always @(posedge clk) rd_pending <= bus_re;

  always @(negedge clk) begin
    if (rd_pending) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  function automatic logic [31:0] model_read(input int unsigned a);
    case (a)
      OFS_RAW:   return {24'h0, m_raw};
      OFS_MASK:  return {24'h0, m_mask};
      OFS_MSTAT: return {24'h0, m_raw & ~m_mask};
      default:   return 32'h0;
    endcase
  endfunction

  task automatic bus_write(input int unsigned a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a[3:0]; bus_wdata = d; bus_we = 1'b1;
    if (a == OFS_MASK) m_mask = d[7:0];
    if (a == OFS_CLR)  m_raw = m_raw & ~d[7:0];
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] e);
    @(negedge clk);
    evt_pulse = e;
    m_raw = m_raw | e;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic collide(input logic [7:0] e, input logic [31:0] c);
    @(negedge clk);
    evt_pulse = e; bus_addr = OFS_CLR[3:0]; bus_wdata = c; bus_we = 1'b1;
    m_raw = (m_raw & ~c[7:0]) | e;
    @(negedge clk);
    evt_pulse = '0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input int unsigned a, input string tag);
    @(negedge clk);
    exp_q.push_back(model_read(a));
    tag_q.push_back(tag);
    bus_addr = a[3:0]; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic check_irq(input logic e, input string tag);
    repeat (2) @(negedge clk);
    checks++;
    if (irq_o !== e) begin
      errors++;
      $display("FAIL %s: irq got %b expected %b", tag, irq_o, e);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_raw = 8'h00; m_mask = 8'hFF;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    bus_read(OFS_RAW,   "R1 raw reset");
    bus_read(OFS_MASK,  "R1 mask reset");
    bus_read(OFS_MSTAT, "R1 masked reset");
    check_irq(1'b0, "R1 irq reset");

    // R2 and R3: each source lands in its own bit while masked
    for (int k = 0; k < 8; k++) begin
      pulse(8'(1 << k));
      bus_read(OFS_RAW, $sformatf("R2 R3 raw after source %0d", k));
    end
    bus_read(OFS_MSTAT, "R6 masked all blocked");
    check_irq(1'b0, "R7 masked sources give no irq");

    // R4 clear semantics
    bus_write(OFS_CLR, 32'h0000_0000);
    bus_read(OFS_RAW, "R4 zero clear no effect");
    bus_write(OFS_CLR, 32'h0000_000F);
    bus_read(OFS_RAW, "R4 partial clear");
    bus_write(OFS_CLR, 32'hFFFF_FFFF);
    bus_read(OFS_RAW, "R4 clear all");

    // R8 and R9 mask write with high bits
    bus_write(OFS_MASK, 32'hFFFF_FF5A);
    bus_read(OFS_MASK, "R8 R9 mask readback");

    // R7 timing: enabled source 0
    @(negedge clk);
    evt_pulse = 8'h01; m_raw = m_raw | 8'h01;
    @(negedge clk);
    evt_pulse = '0;
    checks++;
    if (irq_o !== 1'b0) begin
      errors++; $display("FAIL R7 irq early: got %b expected 0", irq_o);
    end
    @(negedge clk);
    checks++;
    if (irq_o !== 1'b1) begin
      errors++; $display("FAIL R7 irq latency: got %b expected 1", irq_o);
    end
    pulse(8'h02);
    bus_read(OFS_MSTAT, "R6 masked with one enabled");
    bus_read(OFS_RAW,   "R3 raw with masked source");

    // Mask write hides pending source
    bus_write(OFS_MASK, 32'h0000_00FF);
    check_irq(1'b0, "R7 mask blocks pending source");
    bus_write(OFS_MASK, 32'h0000_005A);
    check_irq(1'b1, "R7 unmask restores irq");
    bus_write(OFS_CLR, 32'h0000_0001);
    check_irq(1'b0, "R7 clear drops irq");

    // R5 event against clear in the same cycle
    collide(8'h10, 32'h0000_0012);
    bus_read(OFS_RAW, "R5 event wins over clear");

    // R9 and R10 ignored writes and empty reads
    bus_write(OFS_RAW, 32'hFFFF_FFFF);
    bus_write(OFS_MSTAT, 32'hFFFF_FFFF);
    bus_read(OFS_RAW,  "R9 status writes ignored");
    bus_read(OFS_MASK, "R9 mask unaffected");
    bus_read(OFS_CLR,  "R9 clear reads zero");
    bus_read(5,        "R10 unmapped reads zero");
    bus_read(15,       "R10 top address reads zero");

    // R1 reset from a busy state
    pulse(8'hA5);
    do_reset();
    bus_read(OFS_RAW,  "R1 raw after second reset");
    bus_read(OFS_MASK, "R1 mask after second reset");
    check_irq(1'b0, "R1 irq after second reset");

    repeat (3) @(negedge clk);
    done = 1'b1;
    report();
  end

endmodule